// File: doc/BRIEF.md
# Smart Card Transmit Timing Controller

This block is the transmit half of an asynchronous, half-duplex smart card link. Software writes a byte, and the block shifts out one character on a single open line. The character is a low start bit, eight data bits with the least significant bit first, and a parity bit. Each bit lasts one elementary time unit (etu). The etu is fixed at build time as a count of system clocks.

The block raises a transmit-end flag at a point measured from the leading edge of the start bit. That point is 12.5, 11.5 or 11.0 etu, depending on two bits of the mode register. To place the half-etu points, all timing inside the block is counted in half-etu ticks.

The block also drives the card clock pin from a divided system clock. A 2-bit control field selects the clock behaviour:

- In normal mode the field can only run or stop the clock.
- In the extended mode the field can also park the clock at a high level.
- A stop never cuts a half-period short.

Top module: `smartcard_tx`

## Requirements
- R1: After reset the following hold:
  - mode readback is 0 and clock-control readback is 0.
  - `tx_line` is high.
  - `tx_busy` and `tx_end` are low.
  - `card_clk` is low.
- R2: A frame is sent as follows:
  - Each bit lasts ETU_CLKS clocks, starting from the clock edge after the accepted write.
  - The order is a low start bit, then data bits 0 to 7, then the parity slot.
  - After the parity slot the line returns high, and it stays high whenever no frame is active.
- R3: Mode bit 5 enables parity and mode bit 4 selects its sense.
  - With bit 5 set, the parity slot carries XOR(data) XOR bit 4, so 0 gives even parity and 1 gives odd parity.
  - With bit 5 clear, the parity slot is driven high.
- R4: With mode bit 7 clear and bit 6 clear, `tx_end` rises 12.5 etu (25 half-etu) after the start bit begins.
- R5: With mode bit 7 clear and bit 6 set (block transfer), `tx_end` rises 11.5 etu after the start bit begins.
- R6: With mode bit 7 set, `tx_end` rises 11.0 etu after the start bit begins, whatever the value of bit 6.
- R7: Writing a byte while idle does three things:
  - It starts a frame on the next edge.
  - It clears `tx_end` and sets `tx_busy`.
  - `tx_end` then stays set until the next accepted write.
  A byte write while `tx_busy` is high is ignored, and the frame in flight continues unchanged.
- R8: All 8 mode bits and both clock-control bits read back exactly what was last written, one clock after the write.
- R9: With mode bit 7 clear, clock-control bit 0 decides the clock:
  - When bit 0 is 1, `card_clk` toggles every CCLK_HALF clocks.
  - When bit 0 is 0, `card_clk` settles low.
  - Bit 1 has no effect.
- R10: With mode bit 7 set, the clock-control field works as follows:
  - Value 00 parks `card_clk` low.
  - Value 10 parks it high.
  - Any value with bit 0 set runs the clock with a half-period of CCLK_HALF.
- R11: No level of `card_clk` lasts fewer than CCLK_HALF clocks. A stop or level change waits for the current half-period to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| clkctl_we | input | 1 | Clock-control field write strobe |
| clkctl_wdata | input | 2 | Clock-control write data |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Byte to transmit |
| mode_rdata | output | 8 | Mode register readback |
| clkctl_rdata | output | 2 | Clock-control readback |
| tx_line | output | 1 | Serial I/O line, idles high |
| tx_busy | output | 1 | Frame in progress |
| tx_end | output | 1 | Transmit-end flag |
| card_clk | output | 1 | Card clock output |

## Verification
Faults in the half-etu tick counter show up in two ways:
- A fault in the tick sequencing shows as a bit edge out of place within the first etu of a frame.
- A wrong end point only shows as `tx_end` arriving one or more half-etu early or late, about eleven etu after the start.

A wrong shift-register state corrupts a mid-bit sample of the very bit it affects, and the per-bit scoreboard catches it there.

Card clock faults have their own signatures:
- A clock divider fault is visible as a wrong period within two half-periods.
- A stop that skips the half-period boundary gives a short pulse the moment the control field changes.

// File: rtl/sctx_pkg.sv
package sctx_pkg;

  localparam int MODE_W      = 8;
  localparam int BIT_SPECIAL = 7;
  localparam int BIT_BLOCK   = 6;
  localparam int BIT_PAR_EN  = 5;
  localparam int BIT_ODD     = 4;
  localparam int TICK_W      = 5;

  // end points in half-etu ticks counted from start-bit leading edge
  localparam logic [TICK_W-1:0] END_NORMAL  = 5'd25;
  localparam logic [TICK_W-1:0] END_BLOCK   = 5'd23;
  localparam logic [TICK_W-1:0] END_SPECIAL = 5'd22;

  typedef struct packed {
    logic special;
    logic block;
    logic par_en;
    logic odd;
  } tx_cfg_t;

  function automatic logic [TICK_W-1:0] end_tick(input tx_cfg_t c);
    if (c.special)    return END_SPECIAL;
    else if (c.block) return END_BLOCK;
    else              return END_NORMAL;
  endfunction

  function automatic logic parity_slot(input tx_cfg_t c, input logic [7:0] d);
    if (c.par_en) return (^d) ^ c.odd;
    else          return 1'b1;
  endfunction

endpackage

// File: rtl/sctx_regs.sv
module sctx_regs #(
  parameter int MODE_W = 8,
  parameter int CC_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              cc_we,
  input  logic [CC_W-1:0]   cc_wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic [CC_W-1:0]   cc_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      cc_q   <= '0;
    end else begin
      if (mode_we) mode_q <= mode_wdata;
      if (cc_we)   cc_q   <= cc_wdata;
    end
  end

endmodule

// File: rtl/sctx_frame_tx.sv
module sctx_frame_tx
  import sctx_pkg::*;
#(
  parameter int ETU_CLKS = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  logic [7:0] data_i,
  input  tx_cfg_t   cfg_i,
  output logic      line_o,
  output logic      busy_o,
  output logic      end_o
);

  localparam int HALF  = ETU_CLKS / 2;
  localparam int SUB_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(HALF - 1);
  localparam int FRAME_W = 9;

  logic [SUB_W-1:0]   sub_q;
  logic [TICK_W-1:0]  tick_q;
  logic [TICK_W-1:0]  tick_nx;
  logic [TICK_W-1:0]  stop_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               half_done;

  assign tick_nx   = tick_q + 5'd1;
  assign half_done = (sub_q == SUB_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q   <= '0;
      tick_q  <= '0;
      stop_q  <= END_NORMAL;
      shreg_q <= '1;
      line_o  <= 1'b1;
      busy_o  <= 1'b0;
      end_o   <= 1'b0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o  <= 1'b1;
        end_o   <= 1'b0;
        line_o  <= 1'b0;
        sub_q   <= '0;
        tick_q  <= '0;
        stop_q  <= end_tick(cfg_i);
        shreg_q <= {parity_slot(cfg_i, data_i), data_i};
      end
    end else if (half_done) begin
      sub_q  <= '0;
      tick_q <= tick_nx;
      if (!tick_nx[0]) begin
        line_o  <= shreg_q[0];
        shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
      end
      if (tick_nx == stop_q) begin
        busy_o <= 1'b0;
        end_o  <= 1'b1;
      end
    end else begin
      sub_q <= sub_q + 1'b1;
    end
  end

endmodule

// File: rtl/sctx_cardclk.sv
module sctx_cardclk #(
  parameter int HALF_CLKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic park_level_i,
  output logic cclk_o
);

  localparam int CNT_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             moving;

  // keep toggling until parked at the requested level
  assign moving = run_i || (cclk_o != park_level_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      cclk_o <= 1'b0;
    end else if (moving) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q  <= '0;
        cclk_o <= ~cclk_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

endmodule

// File: rtl/smartcard_tx.sv
module smartcard_tx
  import sctx_pkg::*;
#(
  parameter int ETU_CLKS  = 8,
  parameter int CCLK_HALF = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_we,
  input  logic [7:0] mode_wdata,
  input  logic       clkctl_we,
  input  logic [1:0] clkctl_wdata,
  input  logic       tx_we,
  input  logic [7:0] tx_data,
  output logic [7:0] mode_rdata,
  output logic [1:0] clkctl_rdata,
  output logic       tx_line,
  output logic       tx_busy,
  output logic       tx_end,
  output logic       card_clk
);

  tx_cfg_t cfg;

  sctx_regs #(.MODE_W(MODE_W), .CC_W(2)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .cc_we      (clkctl_we),
    .cc_wdata   (clkctl_wdata),
    .mode_q     (mode_rdata),
    .cc_q       (clkctl_rdata)
  );

  assign cfg.special = mode_rdata[BIT_SPECIAL];
  assign cfg.block   = mode_rdata[BIT_BLOCK];
  assign cfg.par_en  = mode_rdata[BIT_PAR_EN];
  assign cfg.odd     = mode_rdata[BIT_ODD];

  sctx_frame_tx #(.ETU_CLKS(ETU_CLKS)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .start_i (tx_we),
    .data_i  (tx_data),
    .cfg_i   (cfg),
    .line_o  (tx_line),
    .busy_o  (tx_busy),
    .end_o   (tx_end)
  );

  // fixed-high parking exists only in special mode
  sctx_cardclk #(.HALF_CLKS(CCLK_HALF)) u_cclk (
    .clk          (clk),
    .rst          (rst),
    .run_i        (clkctl_rdata[0]),
    .park_level_i (cfg.special & clkctl_rdata[1]),
    .cclk_o       (card_clk)
  );

endmodule

// File: rtl/sctx_checker.sv
module sctx_checker #(
  parameter int CCLK_HALF = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       mode_we,
  input logic [7:0] mode_wdata,
  input logic [7:0] mode_rdata,
  input logic       tx_we,
  input logic       tx_line,
  input logic       tx_busy,
  input logic       tx_end,
  input logic       card_clk
);

  localparam int LEN_W = $clog2(CCLK_HALF + 2) + 1;
  localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(CCLK_HALF);

  logic [LEN_W-1:0] len_q;
  logic             prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= LEN_SAT;
      prev_q <= 1'b0;
    end else begin
      prev_q <= card_clk;
      if (card_clk != prev_q)  len_q <= LEN_W'(1);
      else if (len_q < LEN_SAT) len_q <= len_q + 1'b1;
    end
  end

  assert_min_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (card_clk != prev_q) |-> (len_q >= LEN_SAT));

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> tx_line);

  assert_end_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_end && !tx_we) |=> tx_end);

  assert_start_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_we && !tx_busy) |=> (tx_busy && !tx_end && !tx_line));

  assert_busy_end_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(tx_busy && tx_end));

  assert_mode_readback_R8: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> (mode_rdata == $past(mode_wdata)));

endmodule

bind smartcard_tx sctx_checker #(.CCLK_HALF(CCLK_HALF)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_we    (mode_we),
  .mode_wdata (mode_wdata),
  .mode_rdata (mode_rdata),
  .tx_we      (tx_we),
  .tx_line    (tx_line),
  .tx_busy    (tx_busy),
  .tx_end     (tx_end),
  .card_clk   (card_clk)
);

// File: tb/tb_smartcard_tx.sv
module tb_smartcard_tx;

  localparam int CLK_PERIOD = 10;
  localparam int ETU        = 8;
  localparam int H          = ETU / 2;
  localparam int CCH        = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic       clkctl_we = 1'b0;
  logic [1:0] clkctl_wdata = '0;
  logic       tx_we = 1'b0;
  logic [7:0] tx_data = '0;
  logic [7:0] mode_rdata;
  logic [1:0] clkctl_rdata;
  logic       tx_line, tx_busy, tx_end, card_clk;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] mode_shadow = '0;
  logic [8:0] q_bits[$];
  int         q_tend[$];
  int         frames_done = 0;
  int         min_run = 1000;
  bit         finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smartcard_tx #(.ETU_CLKS(ETU), .CCLK_HALF(CCH)) dut (
    .clk(clk), .rst(rst),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .clkctl_we(clkctl_we), .clkctl_wdata(clkctl_wdata),
    .tx_we(tx_we), .tx_data(tx_data),
    .mode_rdata(mode_rdata), .clkctl_rdata(clkctl_rdata),
    .tx_line(tx_line), .tx_busy(tx_busy), .tx_end(tx_end),
    .card_clk(card_clk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk); mode_we = 1'b1; mode_wdata = v;
    @(negedge clk); mode_we = 1'b0;
    check(mode_rdata == v, "R8 mode readback", mode_rdata, v);
    mode_shadow = v;
  endtask

  task automatic wr_cc(input logic [1:0] v);
    @(negedge clk); clkctl_we = 1'b1; clkctl_wdata = v;
    @(negedge clk); clkctl_we = 1'b0;
    check(clkctl_rdata == v, "R8 clock-control readback", clkctl_rdata, v);
  endtask

  function automatic int exp_end_half(input logic [7:0] m);
    if (m[7])      return 22;
    else if (m[6]) return 23;
    else           return 25;
  endfunction

  // driver: pushes the expected frame, then writes the byte
  task automatic send(input logic [7:0] d, input bit intrude);
    logic p;
    int waited;
    p = mode_shadow[5] ? ((^d) ^ mode_shadow[4]) : 1'b1;
    q_bits.push_back({p, d});
    q_tend.push_back(exp_end_half(mode_shadow) * H);
    @(negedge clk); tx_we = 1'b1; tx_data = d;
    @(negedge clk); tx_we = 1'b0;
    check(tx_busy && !tx_end, "R7 accept clears end and sets busy", {tx_busy, tx_end}, 2);
    if (intrude) begin
      repeat (30) @(negedge clk);
      tx_we = 1'b1; tx_data = ~d;
      @(negedge clk); tx_we = 1'b0;
    end
    waited = 0;
    while (!tx_end && waited < 400) begin @(negedge clk); waited++; end
    repeat (3) @(negedge clk);
    check(tx_end && !tx_busy && tx_line, "R7 end flag holds, line idle high", {tx_end, tx_busy, tx_line}, 5);
  endtask

  // monitor: pops expected frames and compares mid-bit samples and the end point
  initial begin
    logic [8:0] eb;
    logic exp_bit;
    int et, t;
    forever begin
      @(negedge clk);
      if (!rst && !tx_line) begin
        if (q_bits.size() == 0) begin
          check(1'b0, "R7 unexpected frame", 1, 0);
        end else begin
          eb = q_bits.pop_front();
          et = q_tend.pop_front();
          t = 0;
          for (int i = 0; i < 10; i++) begin
            while (t < 2*i*H + H) begin @(negedge clk); t++; end
            exp_bit = (i == 0) ? 1'b0 : eb[i-1];
            check(tx_line == exp_bit, $sformatf("R2/R3 frame bit %0d", i), tx_line, exp_bit);
          end
          while (!tx_end && t < 400) begin @(negedge clk); t++; end
          check(t == et, "R4/R5/R6 end flag time in clocks", t, et);
          frames_done++;
        end
      end
    end
  end

  // card clock run-length monitor (R11)
  initial begin
    logic prev;
    int run;
    prev = 1'b0; run = 0;
    forever begin
      @(negedge clk);
      if (rst) begin prev = card_clk; run = 0; end
      else if (card_clk != prev) begin
        if (run < min_run) min_run = run;
        run = 1; prev = card_clk;
      end else run++;
    end
  end

  task automatic measure_period(input string req);
    int n;
    n = 0;
    while (!(card_clk == 1'b0) && n < 50) begin @(negedge clk); n++; end
    while (card_clk == 1'b0 && n < 100) begin @(negedge clk); n++; end
    n = 0;
    @(negedge clk); n++;
    while (card_clk == 1'b1 && n < 50) begin @(negedge clk); n++; end
    while (card_clk == 1'b0 && n < 50) begin @(negedge clk); n++; end
    check(n == 2*CCH, req, n, 2*CCH);
  endtask

  task automatic hold_level(input logic lvl, input string req);
    bit ok;
    repeat (10) @(negedge clk);
    ok = 1;
    for (int i = 0; i < 12; i++) begin
      if (card_clk != lvl) ok = 0;
      @(negedge clk);
    end
    check(ok, req, card_clk, lvl);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mode_rdata == 8'h00 && clkctl_rdata == 2'b00, "R1 registers reset", {mode_rdata, clkctl_rdata}, 0);
    check(tx_line && !tx_busy && !tx_end && !card_clk, "R1 outputs reset",
          {tx_line, tx_busy, tx_end, card_clk}, 8);

    // frames: normal, even parity
    wr_mode(8'h20);
    send(8'hA5, 0);                  // R4
    send(8'h01, 0);
    wr_mode(8'h30);                  // odd parity R3
    send(8'h3C, 0);
    send(8'h80, 0);
    wr_mode(8'h0F);                  // parity disabled R3, low bits stored R8
    send(8'h7E, 0);
    wr_mode(8'h60);                  // block transfer R5
    send(8'hC3, 0);
    wr_mode(8'hA0);                  // special R6
    send(8'h5A, 0);
    wr_mode(8'hE0);                  // special overrides block R6
    send(8'hFF, 0);
    wr_mode(8'h20);                  // ignored write while busy R7
    send(8'h96, 1);
    check(frames_done == 9 && q_bits.size() == 0, "R7 frame count", frames_done, 9);

    // card clock, normal mode R9
    wr_mode(8'h20);
    wr_cc(2'b01);
    measure_period("R9 running period");
    wr_cc(2'b10);
    hold_level(1'b0, "R9 bit1 ignored, clock low");
    wr_cc(2'b11);
    measure_period("R9 running with bit1 set");
    wr_cc(2'b00);
    hold_level(1'b0, "R9 stopped low");

    // special mode R10
    wr_mode(8'hA0);
    wr_cc(2'b10);
    hold_level(1'b1, "R10 parked high");
    wr_cc(2'b00);
    hold_level(1'b0, "R10 parked low");
    wr_cc(2'b11);
    measure_period("R10 running");
    repeat (2) @(negedge clk);
    wr_cc(2'b10);
    hold_level(1'b1, "R10 stop to high");
    wr_cc(2'b01);
    repeat (4) @(negedge clk);
    wr_cc(2'b00);
    hold_level(1'b0, "R10 stop to low");

    check(min_run >= CCH, "R11 shortest card clock level", min_run, CCH);

    finished = 1;
    summary();
    $finish;
  end

endmodule